// File: doc/BRIEF.md
# Dual-Port Error-Correcting Memory

This block is a two-port memory in which each port has its own clock and can both write and read any word. A word written on either port is first captured in a register and then turned into a single-error-correcting, double-error-detecting codeword, and the codeword is what the array keeps. On a read, the codeword passes through a two-register decoder that returns the repaired data word and a three-bit status. With one check bit per power of two plus one overall parity bit, 64-bit data is kept as 72-bit codewords.

For fault testing, each port carries a parameter mask as wide as a codeword. The mask is XORed into the codeword on that port's read path before decoding, so a chosen set of bit flips can be planted on one port while the other stays clean. A zero mask, the default, leaves the read path untouched. Storage is plain inferred logic at codeword width. To keep each piece of state owned by a single clock, it is split into one bank per port plus a one-bit last-writer table per word.

Top module: `dpecc_ram`

## Requirements
- R1: Codeword layout, with index = position - 1 and positions counted from 1. Data bits fill the positions that are not powers of two, in ascending order, so data bit 0 sits at index 2, bit 1 at index 4 and bit 2 at index 5. Check bit k sits at index 2^k - 1 and gives even parity over all positions whose binary form has bit k set. The top index CW-1 makes the whole codeword even. CW = DATA_W + check bits + 1, which is 72 for 64-bit data.
- R2: A write is captured at the first rising edge of the writing port's clock and stored at the second. A read address is sampled at a rising edge of the port's clock, and data and status change at the second rising edge after that one, three edges counted in all.
- R3: A read on either port returns the data of the most recent completed write to that word, whichever port made it.
- R4: Each port XORs its own codeword-wide parameter mask into the codeword it reads, before decoding. The default mask of zero changes nothing.
- R5: A codeword with zero syndrome and even overall parity returns its data unchanged with status 3'b001.
- R6: A codeword with odd overall parity returns status 3'b010. The data bit the syndrome points at is inverted. A flip in a check bit or in the overall parity bit leaves the data unchanged.
- R7: A codeword with nonzero syndrome and even overall parity returns status 3'b100 and the data bits exactly as received, with no bit inverted.
- R8: Status bit 0 means clean, bit 1 means corrected, bit 2 means uncorrectable. No more than one status bit is ever set.
- R9: The asynchronous reset forces read data and status to zero for as long as it is held. It leaves stored words intact, so they read back correctly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high, shared by both ports |
| clk_a | input | 1 | Port A clock |
| addr_a | input | AW | Port A word address (read, and write when we_a is high) |
| wdata_a | input | DATA_W | Port A write data |
| we_a | input | 1 | Port A write enable |
| rdata_a | output | DATA_W | Port A corrected read data |
| status_a | output | 3 | Port A status {uncorrectable, corrected, clean} |
| clk_b | input | 1 | Port B clock |
| addr_b | input | AW | Port B word address (read, and write when we_b is high) |
| wdata_b | input | DATA_W | Port B write data |
| we_b | input | 1 | Port B write enable |
| rdata_b | output | DATA_W | Port B corrected read data |
| status_b | output | 3 | Port B status {uncorrectable, corrected, clean} |

## Verification
A wrong last-writer table entry shows up as stale data from the other bank on the first read of that word after a write, three edges after the address. A miscoded check bit or a displaced data slot turns a clean read into a corrected or uncorrectable one. It can also make a planted single flip repair the wrong data bit, so every read through the single-bit and double-bit masks exposes it at once. A pipeline stage that is lost or doubled moves the returned word by one cycle. The streamed back-to-back reads catch this on the first sample.

// File: rtl/dpecc_pkg.sv
`timescale 1ns/1ps
package dpecc_pkg;

    // number of Hamming check bits for a data width
    function automatic int chk_w(input int dw);
        int r;
        r = 0;
        for (int t = 0; t < 31; t++) begin
            if (r == 0 && (1 << t) >= dw + t + 1) r = t;
        end
        return r;
    endfunction

    // full codeword width: data, check bits, overall parity
    function automatic int code_w(input int dw);
        return dw + chk_w(dw) + 1;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    typedef enum logic [2:0] {
        ST_NONE  = 3'b000,
        ST_CLEAN = 3'b001,
        ST_FIXED = 3'b010,
        ST_FATAL = 3'b100
    } rd_status_e;

endpackage

// File: rtl/dpecc_enc.sv
`timescale 1ns/1ps
module dpecc_enc
    import dpecc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int PW = chk_w(DATA_W),
    localparam int HW = DATA_W + PW,
    localparam int CW = HW + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     code_o
);

    logic [HW-1:0] hv;

    always_comb begin
        int n;
        hv = '0;
        n  = 0;
        // place data in non power-of-two positions
        for (int pos = 1; pos <= HW; pos++) begin
            if (!is_pow2(pos)) begin
                hv[pos-1] = data_i[n];
                n++;
            end
        end
        // each check bit covers positions holding its bit
        for (int k = 0; k < PW; k++) begin
            for (int pos = 1; pos <= HW; pos++) begin
                if (!is_pow2(pos) && ((pos >> k) & 1) == 1)
                    hv[(1 << k) - 1] = hv[(1 << k) - 1] ^ hv[pos-1];
            end
        end
    end

    assign code_o = {^hv, hv};

endmodule

// File: rtl/dpecc_syn_stage.sv
`timescale 1ns/1ps
module dpecc_syn_stage
    import dpecc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int PW = chk_w(DATA_W),
    localparam int HW = DATA_W + PW,
    localparam int CW = HW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     code_i,
    output logic [PW-1:0]     syn_q,
    output logic              ovr_q,
    output logic [DATA_W-1:0] raw_q
);

    logic [PW-1:0]     syn_d;
    logic [DATA_W-1:0] raw_d;
    logic              ovr_d;

    always_comb begin
        int n;
        syn_d = '0;
        raw_d = '0;
        n     = 0;
        for (int pos = 1; pos <= HW; pos++) begin
            for (int k = 0; k < PW; k++) begin
                if (((pos >> k) & 1) == 1) syn_d[k] = syn_d[k] ^ code_i[pos-1];
            end
            if (!is_pow2(pos)) begin
                raw_d[n] = code_i[pos-1];
                n++;
            end
        end
    end

    assign ovr_d = ^code_i;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            syn_q <= '0;
            ovr_q <= 1'b0;
            raw_q <= '0;
        end else begin
            syn_q <= syn_d;
            ovr_q <= ovr_d;
            raw_q <= raw_d;
        end
    end

endmodule

// File: rtl/dpecc_fix_stage.sv
`timescale 1ns/1ps
module dpecc_fix_stage
    import dpecc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int PW = chk_w(DATA_W),
    localparam int HW = DATA_W + PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PW-1:0]     syn_i,
    input  logic              ovr_i,
    input  logic [DATA_W-1:0] raw_i,
    output logic [DATA_W-1:0] data_o,
    output logic [2:0]        stat_o
);

    logic [DATA_W-1:0] hit;
    logic [DATA_W-1:0] flip;
    rd_status_e        cls;

    // one-hot pointer from syndrome to data slot
    always_comb begin
        int n;
        hit = '0;
        n   = 0;
        for (int pos = 1; pos <= HW; pos++) begin
            if (!is_pow2(pos)) begin
                if (syn_i == PW'(pos)) hit[n] = 1'b1;
                n++;
            end
        end
    end

    always_comb begin
        flip = '0;
        cls  = ST_CLEAN;
        unique case ({ovr_i, |syn_i})
            2'b00: cls = ST_CLEAN;
            2'b01: cls = ST_FATAL;
            default: begin
                cls  = ST_FIXED;
                flip = hit;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            data_o <= '0;
            stat_o <= ST_NONE;
        end else begin
            data_o <= raw_i ^ flip;
            stat_o <= cls;
        end
    end

endmodule

// File: rtl/dpecc_ram.sv
`timescale 1ns/1ps
module dpecc_ram
    import dpecc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    parameter logic [code_w(DATA_W)-1:0] INJ_A = '0,
    parameter logic [code_w(DATA_W)-1:0] INJ_B = '0
) (
    input  logic                     rst,
    input  logic                     clk_a,
    input  logic [$clog2(DEPTH)-1:0] addr_a,
    input  logic [DATA_W-1:0]        wdata_a,
    input  logic                     we_a,
    output logic [DATA_W-1:0]        rdata_a,
    output logic [2:0]               status_a,
    input  logic                     clk_b,
    input  logic [$clog2(DEPTH)-1:0] addr_b,
    input  logic [DATA_W-1:0]        wdata_b,
    input  logic                     we_b,
    output logic [DATA_W-1:0]        rdata_b,
    output logic [2:0]               status_b
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = chk_w(DATA_W);
    localparam int CW = code_w(DATA_W);
    localparam int NP = 2;

    // write capture registers
    logic [DATA_W-1:0] wd_q_a, wd_q_b;
    logic [AW-1:0]     wa_q_a, wa_q_b;
    logic              we_q_a, we_q_b;

    // per-port banks and last-writer table
    logic [CW-1:0]    bank_a [DEPTH];
    logic [CW-1:0]    bank_b [DEPTH];
    logic [DEPTH-1:0] lvt_a, lvt_b;

    // read array registers
    logic [CW-1:0] rcw_a, rcw_b;

    logic [NP-1:0]             clks;
    logic [NP-1:0][DATA_W-1:0] wd_q;
    logic [NP-1:0][CW-1:0]     cw;
    logic [NP-1:0][CW-1:0]     cw_in;
    logic [NP-1:0][PW-1:0]     syn_q;
    logic [NP-1:0]             ovr_q;
    logic [NP-1:0][DATA_W-1:0] raw_q;
    logic [NP-1:0][DATA_W-1:0] rd;
    logic [NP-1:0][2:0]        st;

    assign clks     = {clk_b, clk_a};
    assign wd_q[0]  = wd_q_a;
    assign wd_q[1]  = wd_q_b;
    assign cw_in[0] = rcw_a ^ INJ_A;
    assign cw_in[1] = rcw_b ^ INJ_B;

    // ---------------- port A ----------------
    always_ff @(posedge clk_a or posedge rst) begin
        if (rst) begin
            wd_q_a <= '0;
            wa_q_a <= '0;
            we_q_a <= 1'b0;
        end else begin
            wd_q_a <= wdata_a;
            wa_q_a <= addr_a;
            we_q_a <= we_a;
        end
    end

    always_ff @(posedge clk_a) begin
        if (we_q_a) begin
            bank_a[wa_q_a] <= cw[0];
            lvt_a[wa_q_a]  <= lvt_b[wa_q_a];
        end
    end

    always_ff @(posedge clk_a or posedge rst) begin
        if (rst) rcw_a <= '0;
        else     rcw_a <= (lvt_a[addr_a] == lvt_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
    end

    // ---------------- port B ----------------
    always_ff @(posedge clk_b or posedge rst) begin
        if (rst) begin
            wd_q_b <= '0;
            wa_q_b <= '0;
            we_q_b <= 1'b0;
        end else begin
            wd_q_b <= wdata_b;
            wa_q_b <= addr_b;
            we_q_b <= we_b;
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_q_b) begin
            bank_b[wa_q_b] <= cw[1];
            lvt_b[wa_q_b]  <= ~lvt_a[wa_q_b];
        end
    end

    always_ff @(posedge clk_b or posedge rst) begin
        if (rst) rcw_b <= '0;
        else     rcw_b <= (lvt_a[addr_b] == lvt_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
    end

    // ---------------- codec per port ----------------
    for (genvar p = 0; p < NP; p++) begin : g_port
        dpecc_enc #(.DATA_W(DATA_W)) u_enc (
            .data_i (wd_q[p]),
            .code_o (cw[p])
        );

        dpecc_syn_stage #(.DATA_W(DATA_W)) u_syn (
            .clk    (clks[p]),
            .rst    (rst),
            .code_i (cw_in[p]),
            .syn_q  (syn_q[p]),
            .ovr_q  (ovr_q[p]),
            .raw_q  (raw_q[p])
        );

        dpecc_fix_stage #(.DATA_W(DATA_W)) u_fix (
            .clk    (clks[p]),
            .rst    (rst),
            .syn_i  (syn_q[p]),
            .ovr_i  (ovr_q[p]),
            .raw_i  (raw_q[p]),
            .data_o (rd[p]),
            .stat_o (st[p])
        );
    end

    assign rdata_a  = rd[0];
    assign status_a = st[0];
    assign rdata_b  = rd[1];
    assign status_b = st[1];

endmodule

// File: rtl/dpecc_ram_chk.sv
`timescale 1ns/1ps
module dpecc_ram_chk #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    parameter int PW     = 7
) (
    input logic                     rst,
    input logic                     clk_a,
    input logic                     clk_b,
    input logic [DATA_W-1:0]        rdata_a,
    input logic [2:0]               status_a,
    input logic [DATA_W-1:0]        rdata_b,
    input logic [2:0]               status_b,
    input logic [1:0][PW-1:0]       syn_q,
    input logic [1:0]               ovr_q,
    input logic [1:0][DATA_W-1:0]   raw_q,
    input logic                     we_q_a,
    input logic [$clog2(DEPTH)-1:0] wa_q_a,
    input logic                     we_q_b,
    input logic [$clog2(DEPTH)-1:0] wa_q_b,
    input logic [DEPTH-1:0]         lvt_a,
    input logic [DEPTH-1:0]         lvt_b
);

    // R8
    stat_a_onehot_chk: assert property (@(posedge clk_a) disable iff (rst) $onehot0(status_a));
    // R8
    stat_b_onehot_chk: assert property (@(posedge clk_b) disable iff (rst) $onehot0(status_b));

    // R5
    clean_a_chk: assert property (@(posedge clk_a) disable iff (rst)
        (!ovr_q[0] && syn_q[0] == '0) |=> (status_a == 3'b001 && rdata_a == $past(raw_q[0])));
    // R5
    clean_b_chk: assert property (@(posedge clk_b) disable iff (rst)
        (!ovr_q[1] && syn_q[1] == '0) |=> (status_b == 3'b001 && rdata_b == $past(raw_q[1])));

    // R6
    fixed_a_chk: assert property (@(posedge clk_a) disable iff (rst) ovr_q[0] |=> (status_a == 3'b010));
    // R6
    fixed_b_chk: assert property (@(posedge clk_b) disable iff (rst) ovr_q[1] |=> (status_b == 3'b010));

    // R7
    fatal_a_chk: assert property (@(posedge clk_a) disable iff (rst)
        (!ovr_q[0] && syn_q[0] != '0) |=> (status_a == 3'b100 && rdata_a == $past(raw_q[0])));
    // R7
    fatal_b_chk: assert property (@(posedge clk_b) disable iff (rst)
        (!ovr_q[1] && syn_q[1] != '0) |=> (status_b == 3'b100 && rdata_b == $past(raw_q[1])));

    // R3
    owner_a_chk: assert property (@(posedge clk_a) disable iff (rst)
        we_q_a |=> (lvt_a[$past(wa_q_a)] == lvt_b[$past(wa_q_a)]));
    // R3
    owner_b_chk: assert property (@(posedge clk_b) disable iff (rst)
        we_q_b |=> (lvt_a[$past(wa_q_b)] != lvt_b[$past(wa_q_b)]));

endmodule

bind dpecc_ram dpecc_ram_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .rst      (rst),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rdata_a  (rdata_a),
    .status_a (status_a),
    .rdata_b  (rdata_b),
    .status_b (status_b),
    .syn_q    (syn_q),
    .ovr_q    (ovr_q),
    .raw_q    (raw_q),
    .we_q_a   (we_q_a),
    .wa_q_a   (wa_q_a),
    .we_q_b   (we_q_b),
    .wa_q_b   (wa_q_b),
    .lvt_a    (lvt_a),
    .lvt_b    (lvt_b)
);

// File: tb/test_dpecc_ram.sv
`timescale 1ns/1ps
module test_dpecc_ram;

    localparam int DW    = 64;
    localparam int DEPTH = 512;
    localparam int AW    = 9;
    localparam int CW    = 72;
    // planted flips: index 5 = data bit 2; indices 2,4 = data bits 0,1; index 71 = overall parity
    localparam logic [CW-1:0] M_SGL = 72'd1 << 5;
    localparam logic [CW-1:0] M_DBL = (72'd1 << 2) | (72'd1 << 4);
    localparam logic [CW-1:0] M_OVR = 72'd1 << 71;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst   = 1'b1;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] wdata_a = '0, wdata_b = '0;
    logic we_a = 1'b0, we_b = 1'b0;
    logic [DW-1:0] rd_a0, rd_b0, rd_a1, rd_b1;
    logic [2:0]    st_a0, st_b0, st_a1, st_b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] model [DEPTH];

    always #2 clk_a = ~clk_a;
    initial begin
        #1;
        forever #2 clk_b = ~clk_b;
    end

    // instance 0: port A default mask, port B single data-bit flip
    dpecc_ram #(.DATA_W(DW), .DEPTH(DEPTH), .INJ_B(M_SGL)) i_dpecc_ram (
        .rst(rst),
        .clk_a(clk_a), .addr_a(addr_a), .wdata_a(wdata_a), .we_a(we_a), .rdata_a(rd_a0), .status_a(st_a0),
        .clk_b(clk_b), .addr_b(addr_b), .wdata_b(wdata_b), .we_b(we_b), .rdata_b(rd_b0), .status_b(st_b0)
    );

    // instance 1: port A double flip, port B overall parity flip
    dpecc_ram #(.DATA_W(DW), .DEPTH(DEPTH), .INJ_A(M_DBL), .INJ_B(M_OVR)) i_dpecc_ram_2 (
        .rst(rst),
        .clk_a(clk_a), .addr_a(addr_a), .wdata_a(wdata_a), .we_a(we_a), .rdata_a(rd_a1), .status_a(st_a1),
        .clk_b(clk_b), .addr_b(addr_b), .wdata_b(wdata_b), .we_b(we_b), .rdata_b(rd_b1), .status_b(st_b1)
    );

    function automatic logic [DW-1:0] exp_data(input bit inst, input bit p, input logic [DW-1:0] d);
        return (inst && !p) ? (d ^ 64'h3) : d;
    endfunction

    function automatic logic [2:0] exp_stat(input bit inst, input bit p);
        if (!p) return inst ? 3'b100 : 3'b001;
        return 3'b010;
    endfunction

    task automatic tick(input bit p);
        if (p) @(negedge clk_b);
        else   @(negedge clk_a);
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        tick(p);
        if (p) begin addr_b = a; wdata_b = d; we_b = 1'b1; end
        else   begin addr_a = a; wdata_a = d; we_a = 1'b1; end
        tick(p);
        if (p) we_b = 1'b0; else we_a = 1'b0;
        tick(p);
        tick(p);
        model[a] = d;
    endtask

    task automatic rd(input bit p, input logic [AW-1:0] a);
        tick(p);
        if (p) addr_b = a; else addr_a = a;
        tick(p); tick(p); tick(p);
        if (!p) begin
            chk("R3 R4 R5 port A clean data", rd_a0, exp_data(0, 0, model[a]));
            chk("R5 R8 port A clean status", {61'd0, st_a0}, {61'd0, exp_stat(0, 0)});
            chk("R1 R7 port A double flip data", rd_a1, exp_data(1, 0, model[a]));
            chk("R7 R8 port A double flip status", {61'd0, st_a1}, {61'd0, exp_stat(1, 0)});
        end else begin
            chk("R3 R6 port B data-bit flip data", rd_b0, exp_data(0, 1, model[a]));
            chk("R6 R8 port B data-bit flip status", {61'd0, st_b0}, {61'd0, exp_stat(0, 1)});
            chk("R6 port B parity-bit flip data", rd_b1, exp_data(1, 1, model[a]));
            chk("R6 R8 port B parity-bit flip status", {61'd0, st_b1}, {61'd0, exp_stat(1, 1)});
        end
    endtask

    initial begin
        #700000;
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] seq [7];
        void'($urandom(32'h00C0FFEE));

        // reset state
        repeat (3) tick(0);
        chk("R9 reset data A", rd_a0, '0);
        chk("R9 reset status A", {61'd0, st_a0}, '0);
        chk("R9 reset status B", {61'd0, st_b1}, '0);
        rst = 1'b0;
        tick(0);

        // directed corner patterns
        wr(0, 9'd0, '0);
        wr(1, 9'd1, '1);
        wr(0, 9'd511, 64'hA5A5_5A5A_0F0F_F0F0);
        rd(0, 9'd0); rd(1, 9'd0);
        rd(0, 9'd1); rd(1, 9'd1);
        rd(0, 9'd511); rd(1, 9'd511);

        // last writer wins across ports (R3)
        wr(0, 9'd50, 64'h1111_2222_3333_4444);
        wr(1, 9'd50, 64'h5555_6666_7777_8888);
        rd(0, 9'd50); rd(1, 9'd50);
        wr(0, 9'd50, 64'h9999_AAAA_BBBB_CCCC);
        rd(1, 9'd50); rd(0, 9'd50);

        // streamed reads, latency (R2)
        for (int i = 0; i < 5; i++) wr(0, AW'(40 + i), {32'hDEAD_0000 + 32'(i), $urandom});
        rd(0, 9'd44);
        seq[0] = 9'd40; seq[1] = 9'd41; seq[2] = 9'd42; seq[3] = 9'd43;
        seq[4] = 9'd43; seq[5] = 9'd43; seq[6] = 9'd43;
        for (int j = 0; j < 7; j++) begin
            if (j == 2) chk("R2 no early output", rd_a0, model[44]);
            if (j >= 3) chk("R2 streamed read latency", rd_a0, model[seq[j-3]]);
            addr_a = seq[j];
            tick(0);
        end

        // mid-run reset keeps contents (R9)
        tick(0);
        rst = 1'b1;
        tick(0);
        chk("R9 reset clears data A", rd_a0, '0);
        chk("R9 reset clears status B", {61'd0, st_b0}, '0);
        rst = 1'b0;
        tick(0); tick(0);
        rd(0, 9'd511); rd(1, 9'd50);

        // random traffic on a small window
        for (int a = 0; a < 32; a++) wr(a[0], AW'(a + 64), {$urandom, $urandom});
        for (int it = 0; it < 120; it++) begin
            bit p;
            logic [AW-1:0] a;
            p = 1'($urandom % 2);
            a = AW'(64 + ($urandom % 32));
            if ($urandom % 3 == 0) wr(p, a, {$urandom, $urandom});
            else rd(p, a);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Note: same-word accesses from both ports in overlapping cycles are
    // outside the defined behaviour and are not exercised here.

endmodule